// File: doc/BRIEF.md
# Signed Extrema and Magnitude Unit

This combinational datapath block returns the signed maximum, the signed minimum, the absolute value or the negation of its operands. It treats a data word either as one signed value of the full width or, with the vector flag set, as a row of independent signed lanes. By default the word is 32 bits wide and carries two 16-bit lanes. A negated magnitude that cannot be represented is clamped to the largest positive value of its width, and a per-lane flag reports each clamp.

The unit sits in an ALU slice with no clock of its own. The caller presents two operands, a 2-bit operation code and the vector flag. The result and the clamp flags settle in the same cycle and are registered downstream. ABS and NEG read only the first operand.

Top module: `sgn_extrema_unit`

## Requirements
- R1: With the vector flag low and operation code 0 (MAX), the result is the larger of the two operands compared as signed full-width values, e.g. 0x456789AB and 0x6789ABCD give 0x6789ABCD, and 0x80000000 against 0x00000001 gives 0x00000001.
- R2: With the vector flag low and operation code 1 (MIN), the result is the smaller of the two operands compared as signed full-width values.
- R3: With the vector flag high and code 0 or 1, each lane (lane 0 = least significant bits) independently holds the signed maximum or minimum of the matching operand lanes, e.g. low lanes 0x89AB and 0xABCD give 0xABCD for MAX and 0x89AB for MIN.
- R4: With the vector flag low and code 2 (ABS), a non-negative first operand passes unchanged and a negative one is replaced by its two's complement negation.
- R5: With the vector flag high and code 2, ABS is applied per lane, e.g. 0x456789AB gives 0x45677655.
- R6: Code 3 (NEG) returns the two's complement negation of the first operand, per lane in vector mode (0x456789AB gives 0xBA997655) and over the whole word otherwise (0x456789AB gives 0xBA987655).
- R7: In vector mode, ABS or NEG of a lane holding the most negative lane value (0x8000) yields 0x7FFF in that lane and sets the overflow bit of that lane, leaving the other lanes and their bits unaffected.
- R8: In word mode, ABS or NEG of 0x80000000 yields 0x7FFFFFFF and sets every overflow bit; a word such as 0x80008000 is not clamped in word mode.
- R9: Overflow bits are low for MAX and MIN, and for ABS and NEG whenever no clamp occurs.
- R10: For ABS and NEG the second operand has no effect on the result or the overflow bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | LANE_W*LANES (32) | First operand |
| opb_i | input | LANE_W*LANES (32) | Second operand, read only by MAX and MIN |
| op_sel_i | input | 2 | Operation: 0 MAX, 1 MIN, 2 ABS, 3 NEG |
| vec_i | input | 1 | 1 = independent lanes, 0 = one full-width value |
| res_o | output | LANE_W*LANES (32) | Result |
| lane_ovf_o | output | LANES (2) | Clamp flag per lane; all bits together in word mode |

## Verification
The checks assume the inputs are stable, fully driven two-state values whenever the outputs are sampled. They also assume the result is read only after the combinational paths have settled, because every check is an immediate one evaluated on settled values. The stimulus keeps to this by changing the inputs all at once and waiting a fixed settling delay before comparing. It never drives X or Z. The sweep runs every operand pair, code and mode on a narrow copy with 4-bit lanes, so each lane's most negative value and each ordering of signs are all covered.

// File: rtl/sgn_extrema_pkg.sv
package sgn_extrema_pkg;

    typedef enum logic [1:0] {
        OP_MAX = 2'd0,
        OP_MIN = 2'd1,
        OP_ABS = 2'd2,
        OP_NEG = 2'd3
    } ext_op_e;

    localparam int unsigned DEF_LANE_W = 16;
    localparam int unsigned DEF_LANES  = 2;

    function automatic logic op_reads_b(ext_op_e op);
        return (op == OP_MAX) || (op == OP_MIN);
    endfunction

endpackage

// File: rtl/sgn_extrema_core.sv
module sgn_extrema_core
    import sgn_extrema_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  ext_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic         sat_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

    logic         a_gt_b;
    logic         a_is_min;
    logic [W-1:0] a_neg;

    assign a_gt_b   = $signed(a_i) > $signed(b_i);
    assign a_is_min = (a_i == MOST_NEG);
    assign a_neg    = (~a_i) + ONE;

    always_comb begin
        y_o   = a_i;
        sat_o = 1'b0;
        unique case (op_i)
            OP_MAX: y_o = a_gt_b ? a_i : b_i;
            OP_MIN: y_o = a_gt_b ? b_i : a_i;
            OP_ABS: begin
                if (a_is_min) begin
                    y_o   = MOST_POS;
                    sat_o = 1'b1;
                end else if (a_i[W-1]) begin
                    y_o = a_neg;
                end
            end
            OP_NEG: begin
                if (a_is_min) begin
                    y_o   = MOST_POS;
                    sat_o = 1'b1;
                end else begin
                    y_o = a_neg;
                end
            end
            default: y_o = a_i;
        endcase
    end
endmodule

// File: rtl/sgn_extrema_lanes.sv
module sgn_extrema_lanes
    import sgn_extrema_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 2,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  ext_op_e           op_i,
    output logic [WORD_W-1:0] y_o,
    output logic [LANES-1:0]  sat_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sgn_extrema_core #(.W(LANE_W)) core_i (
            .a_i   (a_i[g*LANE_W +: LANE_W]),
            .b_i   (b_i[g*LANE_W +: LANE_W]),
            .op_i  (op_i),
            .y_o   (y_o[g*LANE_W +: LANE_W]),
            .sat_o (sat_o[g])
        );
    end
endmodule

// File: rtl/sgn_extrema_unit.sv
module sgn_extrema_unit
    import sgn_extrema_pkg::*;
#(
    parameter int unsigned LANE_W = DEF_LANE_W,
    parameter int unsigned LANES  = DEF_LANES,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input  logic [WORD_W-1:0] opa_i,
    input  logic [WORD_W-1:0] opb_i,
    input  logic [1:0]        op_sel_i,
    input  logic              vec_i,
    output logic [WORD_W-1:0] res_o,
    output logic [LANES-1:0]  lane_ovf_o
);
    ext_op_e           op;
    logic [WORD_W-1:0] lane_y;
    logic [LANES-1:0]  lane_sat;
    logic [WORD_W-1:0] word_y;
    logic              word_sat;

    assign op = ext_op_e'(op_sel_i);

    sgn_extrema_lanes #(.LANE_W(LANE_W), .LANES(LANES)) lanes_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .op_i  (op),
        .y_o   (lane_y),
        .sat_o (lane_sat)
    );

    sgn_extrema_core #(.W(WORD_W)) word_i (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .op_i  (op),
        .y_o   (word_y),
        .sat_o (word_sat)
    );

    always_comb begin
        if (vec_i) begin
            res_o      = lane_y;
            lane_ovf_o = lane_sat;
        end else begin
            res_o      = word_y;
            lane_ovf_o = {LANES{word_sat}};
        end
    end
endmodule

// File: rtl/sgn_extrema_chk.sv
module sgn_extrema_chk
    import sgn_extrema_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    parameter int unsigned LANES  = 2,
    localparam int unsigned WORD_W = LANE_W * LANES
) (
    input logic [WORD_W-1:0] opa_i,
    input logic [WORD_W-1:0] opb_i,
    input logic [1:0]        op_sel_i,
    input logic              vec_i,
    input logic [WORD_W-1:0] res_o,
    input logic [LANES-1:0]  lane_ovf_o
);
    localparam logic [WORD_W-1:0] W_POS = {1'b0, {(WORD_W-1){1'b1}}};
    localparam logic [WORD_W-1:0] W_NEG = {1'b1, {(WORD_W-1){1'b0}}};
    localparam logic [LANE_W-1:0] L_POS = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] L_NEG = {1'b1, {(LANE_W-1){1'b0}}};

    always_comb begin
        if (op_reads_b(ext_op_e'(op_sel_i)))
            AST_NO_OVF_ON_COMPARE: assert (lane_ovf_o == '0); // R9
        if (!vec_i && (lane_ovf_o != '0))
            AST_WORD_CLAMP: assert (res_o == W_POS && opa_i == W_NEG && (&lane_ovf_o)); // R8
        if (!vec_i && op_reads_b(ext_op_e'(op_sel_i)))
            AST_WORD_PICKS_OPERAND: assert (res_o == opa_i || res_o == opb_i); // R1
        if (!vec_i && op_sel_i == 2'd2)
            AST_WORD_ABS_NONNEG: assert (res_o[WORD_W-1] == 1'b0); // R4
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lchk
        always_comb begin
            if (vec_i && lane_ovf_o[g])
                AST_LANE_CLAMP: assert (res_o[g*LANE_W +: LANE_W] == L_POS &&
                                        opa_i[g*LANE_W +: LANE_W] == L_NEG); // R7
            if (vec_i && op_reads_b(ext_op_e'(op_sel_i)))
                AST_LANE_PICKS_OPERAND: assert (res_o[g*LANE_W +: LANE_W] == opa_i[g*LANE_W +: LANE_W] ||
                                                res_o[g*LANE_W +: LANE_W] == opb_i[g*LANE_W +: LANE_W]); // R3
            if (vec_i && op_sel_i == 2'd2)
                AST_LANE_ABS_NONNEG: assert (res_o[g*LANE_W + LANE_W - 1] == 1'b0); // R5
        end
    end
endmodule

bind sgn_extrema_unit sgn_extrema_chk #(.LANE_W(LANE_W), .LANES(LANES)) chk_i (
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .op_sel_i   (op_sel_i),
    .vec_i      (vec_i),
    .res_o      (res_o),
    .lane_ovf_o (lane_ovf_o)
);

// File: tb/sgn_extrema_unit_tb_top.sv
module sgn_extrema_unit_tb_top;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] a, b, y;
    logic [1:0]  op;
    logic        vec;
    logic [1:0]  ov;

    sgn_extrema_unit dut_i (
        .opa_i(a), .opb_i(b), .op_sel_i(op), .vec_i(vec), .res_o(y), .lane_ovf_o(ov)
    );

    logic [7:0] sa, sb, sy;
    logic [1:0] sop;
    logic       svec;
    logic [1:0] sov;

    sgn_extrema_unit #(.LANE_W(4), .LANES(2)) dut_s (
        .opa_i(sa), .opb_i(sb), .op_sel_i(sop), .vec_i(svec), .res_o(sy), .lane_ovf_o(sov)
    );

    function automatic void model(input int lw, input int nl, input logic [63:0] ia,
                                  input logic [63:0] ib, input int opc, input bit vm,
                                  output logic [63:0] ey, output logic [7:0] eo);
        int w = vm ? lw : lw * nl;
        int n = vm ? nl : 1;
        longint mask = (longint'(1) << w) - 1;
        longint half = longint'(1) << (w - 1);
        ey = '0;
        eo = '0;
        for (int k = 0; k < n; k++) begin
            longint ua = longint'(ia >> (k * w)) & mask;
            longint ub = longint'(ib >> (k * w)) & mask;
            longint xa = (ua >= half) ? ua - (longint'(1) << w) : ua;
            longint xb = (ub >= half) ? ub - (longint'(1) << w) : ub;
            longint r;
            bit o = 1'b0;
            case (opc)
                0: r = (xa > xb) ? xa : xb;
                1: r = (xa < xb) ? xa : xb;
                2: r = (xa < 0) ? -xa : xa;
                default: r = -xa;
            endcase
            if (r > half - 1) begin r = half - 1; o = 1'b1; end
            ey = ey | (64'(r & mask) << (k * w));
            if (vm) eo[k] = o;
            else if (o) eo = 8'((1 << nl) - 1);
        end
    endfunction

    task automatic check(input string tag, input logic [63:0] gy, input logic [63:0] xy,
                         input logic [7:0] go, input logic [7:0] xo);
        n_run++;
        if (gy !== xy || go !== xo) begin
            n_fail++;
            $display("FAIL %s: got res=%h ovf=%b, expected res=%h ovf=%b", tag, gy, go, xy, xo);
        end
    endtask

    task automatic drive(input logic [31:0] ta, input logic [31:0] tb, input logic [1:0] top,
                         input logic tv);
        a = ta; b = tb; op = top; vec = tv;
        #2;
    endtask

    task automatic dcheck(input string tag, input logic [31:0] ta, input logic [31:0] tb,
                          input logic [1:0] top, input logic tv, input logic [31:0] xy,
                          input logic [1:0] xo);
        drive(ta, tb, top, tv);
        check(tag, 64'(y), 64'(xy), 8'(ov), 8'(xo));
    endtask

    initial begin
        a = '0; b = '0; op = '0; vec = 1'b0;
        sa = '0; sb = '0; sop = '0; svec = 1'b0;
        @(negedge clk);
        #2;
        check("R1 idle zero", 64'(y), 64'h0, 8'(ov), 8'h0);

        dcheck("R1", 32'h456789AB, 32'h6789ABCD, 2'd0, 1'b0, 32'h6789ABCD, 2'b00);
        dcheck("R1", 32'h80000000, 32'h00000001, 2'd0, 1'b0, 32'h00000001, 2'b00);
        dcheck("R1", 32'h7FFF8000, 32'h80007FFF, 2'd0, 1'b0, 32'h7FFF8000, 2'b00);
        dcheck("R2", 32'h456789AB, 32'h6789ABCD, 2'd1, 1'b0, 32'h456789AB, 2'b00);
        dcheck("R2", 32'hFFFFFFFF, 32'h00000000, 2'd1, 1'b0, 32'hFFFFFFFF, 2'b00);
        dcheck("R3", 32'h456789AB, 32'h6789ABCD, 2'd0, 1'b1, 32'h6789ABCD, 2'b00);
        dcheck("R3", 32'h456789AB, 32'h6789ABCD, 2'd1, 1'b1, 32'h456789AB, 2'b00);
        dcheck("R3", 32'h7FFF8000, 32'h80007FFF, 2'd0, 1'b1, 32'h7FFF7FFF, 2'b00);
        dcheck("R3", 32'h7FFF8000, 32'h80007FFF, 2'd1, 1'b1, 32'h80008000, 2'b00);
        dcheck("R4", 32'h456789AB, 32'h0, 2'd2, 1'b0, 32'h456789AB, 2'b00);
        dcheck("R4", 32'hFFFFFFFF, 32'h0, 2'd2, 1'b0, 32'h00000001, 2'b00);
        dcheck("R5", 32'h456789AB, 32'h0, 2'd2, 1'b1, 32'h45677655, 2'b00);
        dcheck("R6", 32'h456789AB, 32'h0, 2'd3, 1'b1, 32'hBA997655, 2'b00);
        dcheck("R6", 32'h456789AB, 32'h0, 2'd3, 1'b0, 32'hBA987655, 2'b00);
        dcheck("R7", 32'h80001234, 32'h0, 2'd2, 1'b1, 32'h7FFF1234, 2'b10);
        dcheck("R7", 32'h12348000, 32'h0, 2'd3, 1'b1, 32'hEDCC7FFF, 2'b01);
        dcheck("R7", 32'h80008000, 32'h0, 2'd3, 1'b1, 32'h7FFF7FFF, 2'b11);
        dcheck("R8", 32'h80000000, 32'h0, 2'd2, 1'b0, 32'h7FFFFFFF, 2'b11);
        dcheck("R8", 32'h80000000, 32'h0, 2'd3, 1'b0, 32'h7FFFFFFF, 2'b11);
        dcheck("R8", 32'h80008000, 32'h0, 2'd2, 1'b0, 32'h7FFF8000, 2'b00);
        dcheck("R9", 32'h80000000, 32'h80000000, 2'd0, 1'b0, 32'h80000000, 2'b00);

        // R10: vary the second operand under ABS/NEG, result must not move
        for (int i = 0; i < 4; i++) begin
            logic [31:0] bv = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFFFFFF :
                              (i == 2) ? 32'h80008000 : 32'h7FFF7FFF;
            dcheck("R10", 32'h8000C001, bv, 2'd2, 1'b1, 32'h7FFF3FFF, 2'b10);
            dcheck("R10", 32'h8000C001, bv, 2'd3, 1'b0, 32'h7FFF3FFF, 2'b00);
        end

        // exhaustive sweep of the narrow copy: every pair, code and mode
        for (int m = 0; m < 2; m++) begin
            for (int o = 0; o < 4; o++) begin
                for (int ia = 0; ia < 256; ia++) begin
                    for (int ib = 0; ib < 256; ib++) begin
                        logic [63:0] ey;
                        logic [7:0]  eo;
                        string tag;
                        sa = 8'(ia); sb = 8'(ib); sop = 2'(o); svec = m[0];
                        #1;
                        model(4, 2, 64'(ia), 64'(ib), o, m[0], ey, eo);
                        if (o >= 2) tag = (eo != 0) ? (m[0] ? "R7" : "R8") :
                                          (o == 3) ? "R6" : (m[0] ? "R5" : "R4");
                        else tag = m[0] ? "R3" : ((o == 0) ? "R1" : "R2");
                        check(tag, 64'(sy), ey, 8'(sov), eo);
                    end
                end
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule